// File: doc/BRIEF.md
# DMA Page Translation Unit

This block turns a linear device DMA address into a physical memory address. The page table it uses lives in system memory and is kept up to date by software. Pages are 4096 bytes. The bits of the DMA address above the in-page offset pick an entry. Each entry is 8 bytes: a 32-bit frame word, followed by a second word that translation never reads. The unit keeps a private copy of the frame words for up to `MAX_ENTRIES` pages. A fetch engine refills that copy from memory each time software writes the table origin or the table length.

Software reaches the unit through two write paths. A configuration write sets the table origin or the table length. The length is given in bytes. A table-window write patches one entry in place without a full refill. Devices send translate requests on a separate port. While a refill is running, requests are held off with `xl_ready` low and `busy` high. An accepted request gets a registered response one cycle later. The response is either a physical address (frame plus in-page offset) or a miss flag.

Top module: `dmt_unit`

## Requirements
- R1: After reset, `busy` and `mem_req` are low, and every translation misses.
- R2: A configuration write with `cfg_sel`=0 (origin) or `cfg_sel`=1 (length) raises `busy` on the next cycle. It then reloads the copy by reading only the frame word of entry i, at origin + 8·i, for i counting up from 0.
- R3: Bit 31 of the origin is forced to zero when the fetch addresses are formed.
- R4: The number of entries fetched is the length in bytes divided by 8 and rounded down, capped at `MAX_ENTRIES`. A length of zero fetches nothing and leaves every page unmapped.
- R5: For an accepted request, the page index is address bits [20:12]. The response arrives one cycle later, with `xl_rsp_paddr` = frame + address[11:0] and `xl_rsp_miss` low.
- R6: A request whose address has any bit from 21 upward set (index at or above 512) misses.
- R7: A page whose frame word is zero misses. A miss response carries `xl_rsp_paddr` = 0.
- R8: A window write with `win_addr[2]`=0 replaces the frame of entry `win_addr`>>3 and maps it, taking effect for the next request. A window write with `win_addr[2]`=1 (the owner word) changes nothing. A window write to an entry index of 512 or more is ignored.
- R9: While `busy` is high, `xl_ready` is low, no request is accepted, and no response is produced.
- R10: `mem_req` stays high with a stable `mem_addr` until `mem_ack` returns the read data.
- R11: Entries at or above the count loaded by the most recent refill miss, until a window write maps them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects table origin, 1 selects table length in bytes |
| cfg_wdata | input | 32 | Configuration write data |
| win_we | input | 1 | Table-window write strobe |
| win_addr | input | 32 | Byte offset into the table for the window write |
| win_wdata | input | 32 | Table-window write data |
| mem_req | output | 1 | Memory read request for a table frame word |
| mem_addr | output | 32 | Memory read byte address |
| mem_ack | input | 1 | Read data valid; completes the request |
| mem_rdata | input | 32 | Read data |
| xl_req | input | 1 | Translate request |
| xl_addr | input | 32 | DMA address to translate |
| xl_ready | output | 1 | Request is accepted when this and `xl_req` are both high |
| xl_rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| xl_rsp_miss | output | 1 | Translation miss |
| xl_rsp_paddr | output | 32 | Translated physical address (0 on a miss) |
| busy | output | 1 | Table refill in progress |

## Verification
If an entry is corrupted or left stale, the very next translate request for that page shows it, one cycle after acceptance: either a wrong physical address or a spurious miss or hit. A wrong fetch counter or a wrong refill length shows up on the memory read port as a wrong address sequence, and as `busy` falling too early or too late. The bench therefore checks every fetch address and the number of fetches per refill. After each refill and each window write it sweeps translations against its own model of the table, so that index truncation or aliasing shows as a mismatch on the entry next to the one touched.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

    localparam int ADDR_W    = 32;
    localparam int PAGE_BITS = 12;
    localparam int ENT_SHIFT = 3;

    typedef enum logic [1:0] {
        LD_IDLE,
        LD_CLEAR,
        LD_FETCH
    } ld_state_t;

    typedef struct packed {
        logic              valid;
        logic              miss;
        logic [ADDR_W-1:0] paddr;
    } xl_rsp_t;

    // Entries covered by a table length in bytes, capped at the array size.
    function automatic logic [31:0] entry_count(input logic [31:0] len_bytes,
                                                input int unsigned max_entries);
        logic [31:0] cap;
        cap = 32'(max_entries) << ENT_SHIFT;
        if (len_bytes >= cap)
            return 32'(max_entries);
        return len_bytes >> ENT_SHIFT;
    endfunction

endpackage

// File: rtl/dmt_loader.sv
module dmt_loader
    import dmt_pkg::*;
#(
    parameter int MAX_ENTRIES = 512,
    parameter int IDX_W       = $clog2(MAX_ENTRIES),
    parameter int CNT_W       = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              clr,
    output logic              ld_we,
    output logic [IDX_W-1:0]  ld_idx,
    output logic [31:0]       ld_data,
    output logic              busy
);

    ld_state_t        state_q;
    logic [31:0]      origin_q;
    logic [31:0]      length_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt;
    logic             last;

    assign cnt  = CNT_W'(entry_count(length_q, MAX_ENTRIES));
    assign last = ({1'b0, idx_q} == cnt - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= LD_IDLE;
            origin_q <= '0;
            length_q <= '0;
            idx_q    <= '0;
        end else if (cfg_we) begin
            if (cfg_sel) length_q <= cfg_wdata;
            else         origin_q <= cfg_wdata;
            state_q <= LD_CLEAR;
            idx_q   <= '0;
        end else begin
            case (state_q)
                LD_CLEAR: state_q <= (cnt == '0) ? LD_IDLE : LD_FETCH;
                LD_FETCH: if (mem_ack) begin
                    if (last) state_q <= LD_IDLE;
                    else      idx_q   <= idx_q + IDX_W'(1);
                end
                default:  state_q <= LD_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != LD_IDLE);
    assign clr      = (state_q == LD_CLEAR);
    assign mem_req  = (state_q == LD_FETCH);
    assign mem_addr = {1'b0, origin_q[30:0]} + (ADDR_W'(idx_q) << ENT_SHIFT);
    assign ld_we    = mem_req && mem_ack && !cfg_we;
    assign ld_idx   = idx_q;
    assign ld_data  = mem_rdata;

endmodule

// File: rtl/dmt_store.sv
module dmt_store #(
    parameter int MAX_ENTRIES = 512,
    parameter int IDX_W       = $clog2(MAX_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             ld_we,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [31:0]      ld_data,
    input  logic             wn_we,
    input  logic [IDX_W-1:0] wn_idx,
    input  logic [31:0]      wn_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_frame,
    output logic             rd_valid
);

    logic [MAX_ENTRIES-1:0] valid_q;
    logic [31:0]            frame_q [MAX_ENTRIES];

    // Valid bits: a refill clears all of them in one cycle; writes set them.
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            if (clr)   valid_q         <= '0;
            if (ld_we) valid_q[ld_idx] <= 1'b1;
            if (wn_we) valid_q[wn_idx] <= 1'b1;
        end
    end

    // Frame words need no reset: they are only read behind a valid bit.
    always_ff @(posedge clk) begin
        if (ld_we) frame_q[ld_idx] <= ld_data;
        if (wn_we) frame_q[wn_idx] <= wn_data;
    end

    assign rd_frame = frame_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];

endmodule

// File: rtl/dmt_lookup.sv
module dmt_lookup
    import dmt_pkg::*;
#(
    parameter int MAX_ENTRIES = 512,
    parameter int IDX_W       = $clog2(MAX_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              ready,
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [31:0]       rd_frame,
    input  logic              rd_valid,
    output xl_rsp_t           rsp
);

    localparam int HI = PAGE_BITS + IDX_W;

    logic in_range;
    logic hit;

    assign rd_idx   = addr[PAGE_BITS +: IDX_W];
    assign in_range = (addr[ADDR_W-1:HI] == '0);
    assign hit      = in_range && rd_valid && (rd_frame != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp <= '0;
        end else begin
            rsp.valid <= req && ready;
            rsp.miss  <= req && ready && !hit;
            rsp.paddr <= (req && ready && hit)
                       ? rd_frame + ADDR_W'(addr[PAGE_BITS-1:0]) : '0;
        end
    end

endmodule

// File: rtl/dmt_unit.sv
module dmt_unit
    import dmt_pkg::*;
#(
    parameter int MAX_ENTRIES = 512
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic        cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic        win_we,
    input  logic [31:0] win_addr,
    input  logic [31:0] win_wdata,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    input  logic        xl_req,
    input  logic [31:0] xl_addr,
    output logic        xl_ready,
    output logic        xl_rsp_valid,
    output logic        xl_rsp_miss,
    output logic [31:0] xl_rsp_paddr,
    output logic        busy
);

    localparam int IDX_W = $clog2(MAX_ENTRIES);
    localparam int WN_HI = IDX_W + ENT_SHIFT;

    logic             clr, ld_we, wn_we, rd_valid;
    logic [IDX_W-1:0] ld_idx, rd_idx;
    logic [31:0]      ld_data, rd_frame;
    xl_rsp_t          rsp;

    // Only the frame word of an in-range entry alters a mapping.
    assign wn_we    = win_we && !win_addr[2] && (win_addr[31:WN_HI] == '0);
    assign xl_ready = !busy;

    dmt_loader #(.MAX_ENTRIES(MAX_ENTRIES), .IDX_W(IDX_W)) u_loader (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .clr(clr), .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
        .busy(busy)
    );

    dmt_store #(.MAX_ENTRIES(MAX_ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst(rst), .clr(clr),
        .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
        .wn_we(wn_we), .wn_idx(win_addr[ENT_SHIFT +: IDX_W]), .wn_data(win_wdata),
        .rd_idx(rd_idx), .rd_frame(rd_frame), .rd_valid(rd_valid)
    );

    dmt_lookup #(.MAX_ENTRIES(MAX_ENTRIES), .IDX_W(IDX_W)) u_lookup (
        .clk(clk), .rst(rst),
        .req(xl_req), .ready(xl_ready), .addr(xl_addr),
        .rd_idx(rd_idx), .rd_frame(rd_frame), .rd_valid(rd_valid),
        .rsp(rsp)
    );

    assign xl_rsp_valid = rsp.valid;
    assign xl_rsp_miss  = rsp.miss;
    assign xl_rsp_paddr = rsp.paddr;

endmodule

// File: rtl/dmt_unit_chk.sv
module dmt_unit_chk #(
    parameter int MAX_ENTRIES = 512
) (
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic        cfg_sel,
    input logic [31:0] cfg_wdata,
    input logic        win_we,
    input logic [31:0] win_addr,
    input logic [31:0] win_wdata,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_ack,
    input logic [31:0] mem_rdata,
    input logic        xl_req,
    input logic [31:0] xl_addr,
    input logic        xl_ready,
    input logic        xl_rsp_valid,
    input logic        xl_rsp_miss,
    input logic [31:0] xl_rsp_paddr,
    input logic        busy
);

    localparam int HI = 12 + $clog2(MAX_ENTRIES);

    // R2: a configuration write makes the unit busy on the next cycle
    a_r2_busy_after_cfg: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> busy);

    // R9: a response exists only for a request accepted while idle
    a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (rst)
        xl_rsp_valid |-> $past(xl_req && xl_ready));

    // R9: no fetch traffic while the unit reports idle
    a_r9_req_implies_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    // R10: an unanswered read keeps its address
    a_r10_hold_addr: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !cfg_we) |=> (mem_req && $stable(mem_addr)));

    // R6: out-of-range index misses
    a_r6_out_of_range: assert property (@(posedge clk) disable iff (rst)
        (xl_req && xl_ready && (xl_addr[31:HI] != '0)) |=> (xl_rsp_valid && xl_rsp_miss));

    // R7: a miss carries a zero address
    a_r7_miss_zero: assert property (@(posedge clk) disable iff (rst)
        xl_rsp_miss |-> (xl_rsp_valid && (xl_rsp_paddr == '0)));

endmodule

bind dmt_unit dmt_unit_chk #(.MAX_ENTRIES(MAX_ENTRIES)) u_chk (.*);

// File: tb/dmt_unit_test.sv
module dmt_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int NENT       = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        win_we = 1'b0;
    logic [31:0] win_addr = '0, win_wdata = '0;
    logic        mem_req, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_rdata = '0;
    logic        xl_req = 1'b0;
    logic [31:0] xl_addr = '0;
    logic        xl_ready, xl_rsp_valid, xl_rsp_miss, busy;
    logic [31:0] xl_rsp_paddr;

    int n_checks = 0, n_fail = 0;

    // bench model of the table
    logic [31:0] m_origin = '0, m_length = '0;
    logic        m_valid [NENT];
    logic [31:0] m_frame [NENT];
    int          fetch_i = 0;
    int          seen_stall;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmt_unit #(.MAX_ENTRIES(NENT)) uut (.*);

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        if (a[5:3] == 3'd3) return 32'h0;
        return (a * 32'h9E3779B1) ^ 32'h0000_0A00;
    endfunction

    function automatic int exp_count(input logic [31:0] len);
        if (len >= 32'(NENT * 8)) return NENT;
        return int'(len >> 3);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory responder: random latency, checks each fetch address (R2, R3)
    always @(negedge clk) begin
        mem_ack = 1'b0;
        if (mem_req && ($urandom % 2 == 0)) begin
            logic [31:0] ea;
            ea = {1'b0, m_origin[30:0]} + 32'(fetch_i * 8);
            check(mem_addr == ea, "R2/R3 fetch address", mem_addr, ea);
            mem_rdata = mem_word(mem_addr);
            mem_ack   = 1'b1;
            fetch_i++;
        end
    end

    task automatic cfg_write(input logic sel, input logic [31:0] v, input bit wait_done);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        check(busy == 1'b1, "R2 busy after cfg", 32'(busy), 1);
        if (sel) m_length = v; else m_origin = v;
        fetch_i = 0;
        for (int i = 0; i < NENT; i++) begin
            m_valid[i] = (i < exp_count(m_length));
            m_frame[i] = mem_word({1'b0, m_origin[30:0]} + 32'(i * 8));
        end
        if (wait_done) begin
            while (busy) @(negedge clk);
            check(fetch_i == exp_count(m_length), "R4 fetch count",
                  32'(fetch_i), 32'(exp_count(m_length)));
        end
    endtask

    task automatic win_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        win_we = 1'b1; win_addr = a; win_wdata = d;
        @(negedge clk);
        win_we = 1'b0;
        if (a < 32'(NENT * 8) && !a[2]) begin
            m_valid[a >> 3] = 1'b1;
            m_frame[a >> 3] = d;
        end
    endtask

    task automatic xlate(input logic [31:0] a, input string req);
        logic [31:0] idx, ep;
        bit          em;
        @(negedge clk);
        xl_req = 1'b1; xl_addr = a;
        seen_stall = 0;
        while (!xl_ready) begin
            check(xl_rsp_valid == 1'b0, "R9 no response while busy", 32'(xl_rsp_valid), 0);
            seen_stall++;
            @(negedge clk);
        end
        @(negedge clk);
        xl_req = 1'b0;
        idx = a >> 12;
        em  = (idx >= NENT) || !m_valid[idx[8:0]] || (m_frame[idx[8:0]] == 0);
        ep  = em ? 32'h0 : m_frame[idx[8:0]] + {20'h0, a[11:0]};
        check(xl_rsp_valid == 1'b1, {req, " response valid"}, 32'(xl_rsp_valid), 1);
        check(xl_rsp_miss == em, {req, " miss flag"}, 32'(xl_rsp_miss), 32'(em));
        check(xl_rsp_paddr == ep, {req, " paddr"}, xl_rsp_paddr, ep);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NENT; i++) begin m_valid[i] = 1'b0; m_frame[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1 busy at reset", 32'(busy), 0);
        check(mem_req == 1'b0, "R1 mem_req at reset", 32'(mem_req), 0);
        xlate(32'h0000_0123, "R1");

        // R2/R3/R4: origin with bit 31 set, full-size length capped
        cfg_write(1'b0, 32'h8001_0000, 1'b1);
        cfg_write(1'b1, 32'd4100, 1'b1);
        for (int i = 0; i < 24; i++) xlate({11'h0, 9'(i * 21), 12'(i * 97)}, "R5");
        xlate(32'h0000_3456, "R7");                  // entry 3 has zero frame
        xlate(32'h0020_0000, "R6");
        xlate(32'hFFFF_F001, "R6");

        // R4/R11: length 20 bytes -> 2 entries
        cfg_write(1'b1, 32'd20, 1'b1);
        xlate(32'h0000_1ABC, "R4 entry 1");
        xlate(32'h0000_2000, "R11 entry 2");
        xlate(32'h001F_F000, "R11 entry 511");

        // R8: window writes
        win_write(32'h0000_0010, 32'h1234_5000);     // frame of entry 2
        xlate(32'h0000_2077, "R8 frame write");
        win_write(32'h0000_0014, 32'hDEAD_B000);     // owner of entry 2
        xlate(32'h0000_2001, "R8 owner ignored");
        win_write(32'h0000_1000, 32'h7777_7000);     // index 512 ignored
        xlate(32'h0000_0FFF, "R8 out of range entry 0");
        win_write(32'h0000_0FF8, 32'h0ABC_D000);     // entry 511
        xlate(32'h001F_FFFF, "R8 last entry");

        // R4: zero length unmaps all
        cfg_write(1'b1, 32'd0, 1'b1);
        xlate(32'h0000_0000, "R4 zero length");
        xlate(32'h0000_2077, "R4 zero length window cleared");

        // R9: request during a refill stalls and then sees the new table
        cfg_write(1'b1, 32'd2048, 1'b0);
        xlate(32'h000F_F010, "R9 stalled");
        check(seen_stall > 0, "R9 stall observed", 32'(seen_stall), 1);

        // random mix
        for (int k = 0; k < 300; k++) begin
            int r = int'($urandom % 20);
            if (r == 0) begin
                win_write({19'h0, 10'($urandom), 3'($urandom & 4)}, $urandom);
            end else if (r == 1 && k % 3 == 0) begin
                cfg_write(1'($urandom), $urandom & 32'h8000_1FFF, 1'b1);
            end else begin
                logic [31:0] a;
                a = $urandom;
                if (r != 2) a[31:21] = '0;
                xlate(a, "R5 random");
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule